// File: doc/BRIEF.md
# Shared interrupt router

The block collects a configurable number of external interrupt sources and routes each one to request pins of a small group of processor cores. Every source carries its own sense setting (polarity, level or edge, single or dual edge), an enable bit, a pending bit, a pin number with a map-enable, and a one-hot core vector. A core sees a request on pin `p` whenever at least one source is pending, enabled and mapped to pin `p` of that core.

Software drives the block through a word-addressed register bus. Single-word write ports enable or disable one source by index, with no read-modify-write. A further write port raises or acknowledges the pending bit of an edge source, which also lets software send interrupts between cores. Each source input passes through a two-flop synchroniser and an edge detector. A two-state machine per source, with states `SRC_QUIET` and `SRC_HELD`, holds the pending bit. The transitions are *assert* (QUIET to HELD on an active level, a detected edge or a software raise), *release* (HELD to QUIET when the level goes inactive, or on an acknowledge with no new edge in the same cycle), and *hold* (all other cases).

Register map (12-bit word address; region in bits [11:8], offset or source index in bits [7:0]):
region 0: offset 0x00 info (RO, bits [7:0] = N with source count (N+1)*8), 0x01 enable-by-index, 0x02 disable-by-index, 0x03 pending raise/acknowledge, 0x10+w pending word w (RO), 0x20+w enable word w (RO); region 1: sense of source s; region 2: pin map of source s; region 3: core vector of source s.

Top module: `irq_router`

## Requirements
- R1: After reset every source is disabled, level-sensitive, active-high, not pending, has pin map and core vector zero, and every request output is low.
- R2: Reading word 0x000 returns NUM_SRC/8-1 in bits [7:0] and zero elsewhere.
- R3: Writing index i (data bits [7:0]) to 0x001 sets enable bit i; writing it to 0x002 clears it. Other bits are unchanged, and an index at or above NUM_SRC changes nothing. Enable word w sits at 0x020+w, source i at bit i%32.
- R4: A level source (sense bit1 = 0) is pending exactly while its input, inverted when sense bit0 = 1, is high. A change of the input shows at the request outputs after the third rising clock edge, counted from the first edge that samples the change.
- R5: An edge source (sense bit1 = 1, bit2 = 0) sets pending on a rising input edge when bit0 = 0, or on a falling edge when bit0 = 1. Pending stays set after the input returns, until it is acknowledged.
- R6: With sense bit2 = 1 an edge source sets pending on both input edges, whatever the value of bit0.
- R7: A write to 0x003 with data bit 31 = 1 sets the pending bit of source data[7:0]; with bit 31 = 0 it clears it (acknowledge). When an edge and an acknowledge arrive in the same cycle, the edge wins. Writes to 0x003 have no effect on level sources.
- R8: Request output bit c*NUM_PIN+p is high exactly when some source is pending and enabled, has its map-enable set, has pin number p, and has bit c set in its core vector.
- R9: A source whose map-enable (pin register bit 31) is 0, or whose enable bit is 0, drives no request, while its pending bit remains readable at 0x010+w.
- R10: Sense (bits [2:0]), pin map (pin in the low bits, map-enable in bit 31) and core vector registers read back as written at 0x100+s, 0x200+s and 0x300+s. Indices at or above NUM_SRC read zero. Reads return data on the clock edge that follows the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | External source inputs, asynchronous |
| bus_wr_en | input | 1 | Register write strobe |
| bus_wr_addr | input | 12 | Write word address |
| bus_wr_data | input | 32 | Write data |
| bus_rd_en | input | 1 | Register read strobe |
| bus_rd_addr | input | 12 | Read word address |
| bus_rd_data | output | 32 | Read data, registered |
| irq_req | output | NUM_CORE*NUM_PIN | Per-core request pins, bit c*NUM_PIN+p |

## Verification
The bench measures the three-edge input latency exactly. A design with one synchroniser flop too few or too many would raise the request one cycle early or late. It also times an acknowledge to land in the same cycle as a fresh edge: a design that lets the acknowledge win would drop that interrupt. Polarity under dual-edge sensing, software raises aimed at level sources, and out-of-range enable indices are each driven and read back, because a design that decodes them wrongly corrupts a neighbouring source. A walking-one sweep over all sources, under a mixed pin and core map, checks every request bit against an arithmetic model and would catch a wrong core or pin index, or a map-enable that is ignored.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    // address regions, decoded from bits [11:8]
    localparam logic [3:0] RGN_GLOBAL = 4'h0;
    localparam logic [3:0] RGN_SENSE  = 4'h1;
    localparam logic [3:0] RGN_PIN    = 4'h2;
    localparam logic [3:0] RGN_CORE   = 4'h3;

    // offsets inside the global region
    localparam logic [7:0] OFF_INFO     = 8'h00;
    localparam logic [7:0] OFF_EN_SET   = 8'h01;
    localparam logic [7:0] OFF_EN_CLR   = 8'h02;
    localparam logic [7:0] OFF_PEND_CTL = 8'h03;
    localparam int         OFF_PEND_RD  = 16;
    localparam int         OFF_EN_RD    = 32;

    localparam int RAISE_BIT  = 31;
    localparam int MAP_EN_BIT = 31;

    typedef struct packed {
        logic both_edges;   // bit 2
        logic edge_trig;    // bit 1
        logic invert;       // bit 0
    } sense_cfg_t;

    typedef enum logic {
        SRC_QUIET = 1'b0,
        SRC_HELD  = 1'b1
    } src_state_e;

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
    import irq_router_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       src_async,
    input  sense_cfg_t sense,
    input  logic       sw_raise,
    input  logic       sw_ack,
    output logic       pending
);

    logic       meta_q, sync_q, prev_q;
    logic       rise, fall, edge_seen, level_on, raise_any;
    src_state_e state_q, state_d;

    // two-flop synchroniser followed by the edge history flop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= src_async;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise      = sync_q & ~prev_q;
    assign fall      = ~sync_q & prev_q;
    assign edge_seen = sense.both_edges ? (rise | fall)
                                        : (sense.invert ? fall : rise);
    assign level_on  = sync_q ^ sense.invert;
    assign raise_any = edge_seen | sw_raise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SRC_QUIET;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRC_QUIET: begin
                if (!sense.edge_trig) state_d = level_on  ? SRC_HELD : SRC_QUIET;
                else                  state_d = raise_any ? SRC_HELD : SRC_QUIET;
            end
            SRC_HELD: begin
                if (!sense.edge_trig)           state_d = level_on ? SRC_HELD : SRC_QUIET;
                else if (sw_ack && !raise_any)  state_d = SRC_QUIET;
                else                            state_d = SRC_HELD;
            end
            default: state_d = SRC_QUIET;
        endcase
    end

    // outputs
    always_comb begin
        pending = (state_q == SRC_HELD);
    end

endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int PIN_W    = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_en,
    input  logic [ADDR_W-1:0]                   wr_addr,
    input  logic [DATA_W-1:0]                   wr_data,
    input  logic                                rd_en,
    input  logic [ADDR_W-1:0]                   rd_addr,
    output logic [DATA_W-1:0]                   rd_data,
    input  logic [NUM_SRC-1:0]                  pend_vec,
    output sense_cfg_t [NUM_SRC-1:0]            sense_q,
    output logic [NUM_SRC-1:0]                  enable_q,
    output logic [NUM_SRC-1:0][PIN_W-1:0]       pin_num_q,
    output logic [NUM_SRC-1:0]                  map_en_q,
    output logic [NUM_SRC-1:0][NUM_CORE-1:0]    core_vec_q,
    output logic [NUM_SRC-1:0]                  raise_vec,
    output logic [NUM_SRC-1:0]                  ack_vec
);

    localparam int WORDS  = (NUM_SRC + 31) / 32;
    localparam int PAD_W  = WORDS * 32;
    localparam int SIDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [3:0]        wr_rgn, rd_rgn;
    logic [7:0]        wr_idx, rd_idx, tgt_idx;
    logic              is_global, en_set_op, en_clr_op, pend_op;
    logic              rd_in_range;
    logic [SIDX_W-1:0] rd_sel;
    logic [PAD_W-1:0]  pend_pad, en_pad;
    logic [DATA_W-1:0] rd_next;

    assign wr_rgn    = wr_addr[11:8];
    assign wr_idx    = wr_addr[7:0];
    assign tgt_idx   = wr_data[7:0];
    assign is_global = wr_en && (wr_rgn == RGN_GLOBAL);
    assign en_set_op = is_global && (wr_idx == OFF_EN_SET);
    assign en_clr_op = is_global && (wr_idx == OFF_EN_CLR);
    assign pend_op   = is_global && (wr_idx == OFF_PEND_CTL);

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
        logic idx_hit, tgt_hit;
        assign idx_hit = wr_en && (wr_idx == 8'(s));
        assign tgt_hit = (tgt_idx == 8'(s));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sense_q[s]    <= '0;
                pin_num_q[s]  <= '0;
                map_en_q[s]   <= 1'b0;
                core_vec_q[s] <= '0;
                enable_q[s]   <= 1'b0;
            end else begin
                if (idx_hit && wr_rgn == RGN_SENSE) sense_q[s] <= wr_data[2:0];
                if (idx_hit && wr_rgn == RGN_PIN) begin
                    pin_num_q[s] <= wr_data[PIN_W-1:0];
                    map_en_q[s]  <= wr_data[MAP_EN_BIT];
                end
                if (idx_hit && wr_rgn == RGN_CORE) core_vec_q[s] <= wr_data[NUM_CORE-1:0];
                if (en_set_op && tgt_hit)      enable_q[s] <= 1'b1;
                else if (en_clr_op && tgt_hit) enable_q[s] <= 1'b0;
            end
        end

        assign raise_vec[s] = pend_op && tgt_hit &&  wr_data[RAISE_BIT];
        assign ack_vec[s]   = pend_op && tgt_hit && !wr_data[RAISE_BIT];
    end

    // read path
    assign rd_rgn      = rd_addr[11:8];
    assign rd_idx      = rd_addr[7:0];
    assign rd_in_range = ({1'b0, rd_idx} < 9'(NUM_SRC));
    assign rd_sel      = rd_idx[SIDX_W-1:0];
    assign pend_pad    = PAD_W'(pend_vec);
    assign en_pad      = PAD_W'(enable_q);

    always_comb begin
        rd_next = '0;
        case (rd_rgn)
            RGN_GLOBAL: begin
                if (rd_idx == OFF_INFO) rd_next = DATA_W'(NUM_SRC / 8 - 1);
                for (int w = 0; w < WORDS; w++) begin
                    if (rd_idx == 8'(OFF_PEND_RD + w)) rd_next = pend_pad[w*32 +: 32];
                    if (rd_idx == 8'(OFF_EN_RD + w))   rd_next = en_pad[w*32 +: 32];
                end
            end
            RGN_SENSE: if (rd_in_range) rd_next = {29'b0, sense_q[rd_sel]};
            RGN_PIN:   if (rd_in_range)
                rd_next = {map_en_q[rd_sel], (DATA_W-1-PIN_W)'(0), pin_num_q[rd_sel]};
            RGN_CORE:  if (rd_in_range) rd_next = DATA_W'(core_vec_q[rd_sel]);
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= rd_next;
    end

    logic unused_wdata;
    assign unused_wdata = ^wr_data;

endmodule

// File: rtl/irq_route.sv
module irq_route #(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int NUM_PIN  = 4,
    parameter int PIN_W    = 2
) (
    input  logic [NUM_SRC-1:0]               active,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]    pin_num,
    input  logic [NUM_SRC-1:0]               map_en,
    input  logic [NUM_SRC-1:0][NUM_CORE-1:0] core_vec,
    output logic [NUM_CORE*NUM_PIN-1:0]      req
);

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int s = 0; s < NUM_SRC; s++) begin
                    if (active[s] && map_en[s] && core_vec[s][c] &&
                        (pin_num[s] == PIN_W'(p)))
                        hit = 1'b1;
                end
            end
            assign req[c*NUM_PIN + p] = hit;
        end
    end

endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_SRC  = 16,
    parameter int NUM_CORE = 2,
    parameter int NUM_PIN  = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           irq_in,
    input  logic                         bus_wr_en,
    input  logic [ADDR_W-1:0]            bus_wr_addr,
    input  logic [DATA_W-1:0]            bus_wr_data,
    input  logic                         bus_rd_en,
    input  logic [ADDR_W-1:0]            bus_rd_addr,
    output logic [DATA_W-1:0]            bus_rd_data,
    output logic [NUM_CORE*NUM_PIN-1:0]  irq_req
);

    localparam int PIN_W = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;

    sense_cfg_t [NUM_SRC-1:0]           sense_q;
    logic [NUM_SRC-1:0]                 enable_vec, pend_vec, edge_vec;
    logic [NUM_SRC-1:0]                 raise_vec, ack_vec, map_en_vec;
    logic [NUM_SRC-1:0][PIN_W-1:0]      pin_num;
    logic [NUM_SRC-1:0][NUM_CORE-1:0]   core_vec;

    irq_regfile #(
        .NUM_SRC (NUM_SRC),
        .NUM_CORE(NUM_CORE),
        .PIN_W   (PIN_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (bus_wr_en),
        .wr_addr   (bus_wr_addr),
        .wr_data   (bus_wr_data),
        .rd_en     (bus_rd_en),
        .rd_addr   (bus_rd_addr),
        .rd_data   (bus_rd_data),
        .pend_vec  (pend_vec),
        .sense_q   (sense_q),
        .enable_q  (enable_vec),
        .pin_num_q (pin_num),
        .map_en_q  (map_en_vec),
        .core_vec_q(core_vec),
        .raise_vec (raise_vec),
        .ack_vec   (ack_vec)
    );

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_cell
        irq_src_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_async(irq_in[s]),
            .sense    (sense_q[s]),
            .sw_raise (raise_vec[s]),
            .sw_ack   (ack_vec[s]),
            .pending  (pend_vec[s])
        );
        assign edge_vec[s] = sense_q[s].edge_trig;
    end

    irq_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_CORE(NUM_CORE),
        .NUM_PIN (NUM_PIN),
        .PIN_W   (PIN_W)
    ) u_route (
        .active  (pend_vec & enable_vec),
        .pin_num (pin_num),
        .map_en  (map_en_vec),
        .core_vec(core_vec),
        .req     (irq_req)
    );

endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
    parameter int NUM_SRC = 16,
    parameter int REQ_W   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [11:0]        wr_addr,
    input logic [31:0]        wr_data,
    input logic [NUM_SRC-1:0] enable_vec,
    input logic [NUM_SRC-1:0] pend_vec,
    input logic [NUM_SRC-1:0] edge_vec,
    input logic [REQ_W-1:0]   irq_req
);

    logic [NUM_SRC-1:0] set_hit, clr_hit, ack_hit;

    always_comb begin
        set_hit = '0;
        clr_hit = '0;
        ack_hit = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (wr_en && wr_addr == 12'h001 && wr_data[7:0] == 8'(s)) set_hit[s] = 1'b1;
            if (wr_en && wr_addr == 12'h002 && wr_data[7:0] == 8'(s)) clr_hit[s] = 1'b1;
            if (wr_en && wr_addr == 12'h003 && wr_data[7:0] == 8'(s) && !wr_data[31])
                ack_hit[s] = 1'b1;
        end
    end

    // R3
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_hit) |=> ((enable_vec & $past(set_hit)) == $past(set_hit)));

    // R3
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_hit) |=> ((enable_vec & $past(clr_hit)) == '0));

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend_vec & edge_vec & ~ack_hit) & ~pend_vec) == '0));

    // R8
    req_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_req) |-> (|(pend_vec & enable_vec)));

    // R9
    req_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enable_vec == '0) |-> (irq_req == '0));

    logic unused_data;
    assign unused_data = ^wr_data[30:8];

endmodule

bind irq_router irq_router_chk #(
    .NUM_SRC(NUM_SRC),
    .REQ_W  (NUM_CORE*NUM_PIN)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (bus_wr_en),
    .wr_addr   (bus_wr_addr),
    .wr_data   (bus_wr_data),
    .enable_vec(enable_vec),
    .pend_vec  (pend_vec),
    .edge_vec  (edge_vec),
    .irq_req   (irq_req)
);

// File: tb/irq_router_bench.sv
`timescale 1ns/1ps
module irq_router_bench;

    localparam int NS = 16;
    localparam int NC = 2;
    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in = '0;
    logic          wr_en = 1'b0;
    logic [11:0]   wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          rd_en = 1'b0;
    logic [11:0]   rd_addr = '0;
    logic [31:0]   rd_data;
    logic [NC*NP-1:0] irq_req;

    int checks = 0;
    int errors = 0;

    logic [NS-1:0] m_en;
    logic [1:0]    m_pin  [NS];
    logic [NC-1:0] m_core [NS];

    irq_router #(.NUM_SRC(NS), .NUM_CORE(NC), .NUM_PIN(NP)) u_irq_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .bus_wr_en(wr_en), .bus_wr_addr(wr_addr), .bus_wr_data(wr_data),
        .bus_rd_en(rd_en), .bus_rd_addr(rd_addr), .bus_rd_data(rd_data),
        .irq_req(irq_req)
    );

    always #2 clk = ~clk;

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic check_rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    function automatic logic [NC*NP-1:0] model_req(input logic [NS-1:0] act);
        logic [NC*NP-1:0] r = '0;
        for (int s = 0; s < NS; s++)
            if (act[s] && m_en[s])
                for (int c = 0; c < NC; c++)
                    if (m_core[s][c]) r[c*NP + int'(m_pin[s])] = 1'b1;
        return r;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] pat;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // reset state
        check("R1 requests", 32'(irq_req), 32'h0);
        check_rd("R1 enable word", 12'h020, 32'h0);
        check_rd("R1 pending word", 12'h010, 32'h0);
        check_rd("R2 info", 12'h000, 32'h1);
        check_rd("R1 sense src0", 12'h100, 32'h0);

        // src 3 level, pin 1, core 0
        wr(12'h203, 32'h8000_0001);
        wr(12'h303, 32'h1);
        wr(12'h001, 32'd3);
        check_rd("R10 pin map src3", 12'h203, 32'h8000_0001);
        check_rd("R10 core src3", 12'h303, 32'h1);
        check_rd("R3 enable after set", 12'h020, 32'h8);

        irq_in[3] = 1'b1;
        tick(2);
        check("R4 not before third edge", 32'(irq_req), 32'h0);
        tick(1);
        check("R4 request at third edge", 32'(irq_req), 32'h2);
        irq_in[3] = 1'b0;
        tick(3);
        check("R4 level release", 32'(irq_req), 32'h0);
        wr(12'h103, 32'h1);
        tick(2);
        check("R4 inverted level", 32'(irq_req), 32'h2);
        wr(12'h103, 32'h0);

        // enable ports
        wr(12'h001, 32'd5);
        wr(12'h001, 32'd9);
        check_rd("R3 set two", 12'h020, 32'h228);
        wr(12'h002, 32'd5);
        check_rd("R3 clear one", 12'h020, 32'h208);
        wr(12'h001, 32'd20);
        check_rd("R3 out of range ignored", 12'h020, 32'h208);
        wr(12'h002, 32'd9);
        wr(12'h002, 32'd3);
        check_rd("R3 all cleared", 12'h020, 32'h0);

        // single edge, rising
        wr(12'h102, 32'h2);
        irq_in[2] = 1'b1; tick(3);
        irq_in[2] = 1'b0; tick(3);
        check_rd("R5 rising latched", 12'h010, 32'h4);
        wr(12'h003, 32'd2);
        check_rd("R5 acknowledged", 12'h010, 32'h0);
        // single edge, falling
        wr(12'h102, 32'h3);
        irq_in[2] = 1'b1; tick(3);
        check_rd("R5 falling ignores rise", 12'h010, 32'h0);
        irq_in[2] = 1'b0; tick(3);
        check_rd("R5 falling latched", 12'h010, 32'h4);
        wr(12'h003, 32'd2);

        // dual edge with polarity bit set
        wr(12'h104, 32'h7);
        irq_in[4] = 1'b1; tick(3);
        check_rd("R6 dual rise", 12'h010, 32'h10);
        wr(12'h003, 32'd4);
        check_rd("R6 dual ack", 12'h010, 32'h0);
        irq_in[4] = 1'b0; tick(3);
        check_rd("R6 dual fall", 12'h010, 32'h10);
        wr(12'h003, 32'd4);

        // raise / acknowledge port
        wr(12'h106, 32'h2);
        irq_in[6] = 1'b1;
        tick(2);
        wr(12'h003, 32'd6);
        check_rd("R7 edge beats ack", 12'h010, 32'h40);
        wr(12'h003, 32'd6);
        irq_in[6] = 1'b0; tick(3);
        check_rd("R7 acked, fall ignored", 12'h010, 32'h0);
        wr(12'h003, 32'h8000_0006);
        check_rd("R7 software raise", 12'h010, 32'h40);
        wr(12'h003, 32'd6);
        wr(12'h003, 32'h8000_0007);
        check_rd("R7 level ignores raise", 12'h010, 32'h0);

        check_rd("R10 sense src4", 12'h104, 32'h7);
        check_rd("R10 out of range", 12'h120, 32'h0);

        // routing sweep
        for (int s = 0; s < NS; s++) begin
            m_en[s]   = (s != 15);
            m_pin[s]  = 2'(s % 4);
            m_core[s] = NC'((s % 3) + 1);
            wr(12'h100 + 12'(s), 32'h0);
            wr(12'h200 + 12'(s), {m_en[s], 29'b0, m_pin[s]});
            wr(12'h300 + 12'(s), 32'(m_core[s]));
            wr(12'h001, 32'(s));
        end
        for (int i = 0; i < NS + 3; i++) begin
            pat = (i < NS) ? 16'(1 << i) : (i == NS) ? 16'hFFFF : (i == NS + 1) ? 16'hA5C3 : 16'h0;
            irq_in = pat;
            tick(3);
            check((i == 15) ? "R9 map disabled" : "R8 routing", 32'(irq_req), 32'(model_req(pat)));
        end

        // disabled but pending
        wr(12'h002, 32'd1);
        irq_in = 16'h0002;
        tick(3);
        check("R9 disabled source", 32'(irq_req), 32'h0);
        check_rd("R9 still pending", 12'h010, 32'h2);
        irq_in = '0;
        tick(3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule